// File: doc/BRIEF.md
# Stream Arm/Disarm Sequencer

This block is the control sequencer that turns a host request into the ordered handshakes needed to start or stop a continuous streaming transfer. A command strobe arrives with a 16-bit value. A nonzero value asks for streaming to begin and a zero value asks for it to end. If the source reports that it is not active, the request is always taken as a stop. The block answers every command with a one-cycle acknowledge.

To start, the block loads the transfer engine with a very large transfer count and clears the byte count. It then pulls the source's stream enable low and fires a single initial transfer. When the engine reports done, it releases the enable, fires the continuous-read trigger and lowers the active-low streaming indicator.

To stop, the block raises the indicator and forces a buffer flush. It then waits for the engine to go idle, skips the partial packet and returns all three source control lines high. A start while already streaming, or a stop while idle, only acknowledges. A command that arrives while a sequence runs goes into a single holding slot. The newest held command wins, and it is served once the running sequence has been acknowledged.

Top module: `stream_arm_sequencer`

## Requirements
- R1: After reset the streaming indicator and all three source control lines (srcCtlN[2:0]) are high, no pulse output is asserted and the block is not streaming.
- R2: A start (command value nonzero with source active, while not streaming) pulses loadCount together with clearBytes, and xferCount then holds 0x80 in its top byte and zero elsewhere.
- R3: In a start, initTrig pulses one cycle after loadCount with srcCtlN[0] (the stream enable) low. srcCtlN[0] stays low until contTrig pulses, and in that cycle srcCtlN[0] is high again and streamIndN is low.
- R4: A stop (command value zero, while streaming) pulses flushPulse in the cycle streamIndN goes high. skipPulse follows, and in its cycle srcCtlN reads 3'b111.
- R5: With srcActive low at the command strobe, any command value is handled as a stop.
- R6: A start while streaming or a stop while not streaming produces no sequence pulse and leaves srcCtlN and streamIndN unchanged.
- R7: Every command gets exactly one cmdAck pulse one cycle long. It comes one cycle after contTrig for a start and one cycle after skipPulse for a stop.
- R8: A command strobed while a sequence is running is held and served after that sequence's acknowledge. If several arrive, only the last one is kept.
- R9: Each wait stage advances on the first clock edge that samples xferDone high. The enable stays low for exactly two cycles plus the number of cycles xferDone was held low, and the flush-to-skip distance is the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Command strobe, one cycle |
| cmdValue | input | 16 | Command value; nonzero requests start |
| srcActive | input | 1 | Source is active and may stream |
| xferDone | input | 1 | Transfer engine idle / done |
| loadCount | output | 1 | Pulse: load transfer count |
| xferCount | output | 32 | Transfer count to load |
| clearBytes | output | 1 | Pulse: clear the byte count |
| initTrig | output | 1 | Pulse: one-shot initial transfer |
| contTrig | output | 1 | Pulse: continuous-read trigger |
| srcCtlN | output | 3 | Active-low source control lines; bit 0 is stream enable |
| streamIndN | output | 1 | Active-low streaming indicator |
| flushPulse | output | 1 | Pulse: force buffer flush |
| skipPulse | output | 1 | Pulse: skip the partial packet |
| cmdAck | output | 1 | Pulse: command acknowledged |

## Verification
The hardest case to reach is a command that lands in the holding slot while a start is parked in its wait stage, with a second command replacing the first before the slot is served. The bench holds xferDone low for several cycles after the initial trigger and strobes two commands into that window. It then checks that only the last one is served, and only after the first acknowledge. The remaining behaviour is swept across both starting stream states, both source-active values, several command values and done delays of zero to three cycles. Every pulse-to-pulse distance is computed from the delay.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LOAD,
    ST_ENLOW,
    ST_WAITINIT,
    ST_RUN,
    ST_INDHIGH,
    ST_WAITIDLE,
    ST_SKIP,
    ST_ACK
  } seqState_t;

  typedef struct packed {
    logic setFlag;
    logic clrFlag;
    logic loadCount;
    logic clearBytes;
    logic initTrig;
    logic contTrig;
    logic enLow;
    logic enHigh;
    logic indLow;
    logic indHigh;
    logic flush;
    logic skip;
    logic ctlAllHigh;
    logic ack;
  } seqStrobe_t;

endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
#(
  parameter int CMD_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [CMD_W-1:0] cmdValue,
  input  logic             srcActive,
  input  logic             xferDone,
  input  logic             streaming,
  output seqStrobe_t       strobe
);

  seqState_t state, nextState;
  logic holdValid;
  logic holdStart;

  // single holding slot, newest command wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdValid <= 1'b0;
      holdStart <= 1'b0;
    end else if (cmdValid) begin
      holdValid <= 1'b1;
      holdStart <= srcActive && (cmdValue != '0);
    end else if (state == ST_IDLE && holdValid) begin
      holdValid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (holdValid) begin
          if (holdStart && !streaming)      nextState = ST_LOAD;
          else if (!holdStart && streaming) nextState = ST_INDHIGH;
          else                              nextState = ST_ACK;
        end
      end
      ST_LOAD: begin
        strobe.setFlag    = 1'b1;
        strobe.loadCount  = 1'b1;
        strobe.clearBytes = 1'b1;
        nextState         = ST_ENLOW;
      end
      ST_ENLOW: begin
        strobe.enLow    = 1'b1;
        strobe.initTrig = 1'b1;
        nextState       = ST_WAITINIT;
      end
      ST_WAITINIT: begin
        if (xferDone) nextState = ST_RUN;
      end
      ST_RUN: begin
        strobe.enHigh   = 1'b1;
        strobe.contTrig = 1'b1;
        strobe.indLow   = 1'b1;
        nextState       = ST_ACK;
      end
      ST_INDHIGH: begin
        strobe.indHigh = 1'b1;
        strobe.flush   = 1'b1;
        nextState      = ST_WAITIDLE;
      end
      ST_WAITIDLE: begin
        if (xferDone) nextState = ST_SKIP;
      end
      ST_SKIP: begin
        strobe.skip       = 1'b1;
        strobe.clrFlag    = 1'b1;
        strobe.ctlAllHigh = 1'b1;
        nextState         = ST_ACK;
      end
      ST_ACK: begin
        strobe.ack = 1'b1;
        nextState  = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  AST_LOAD_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadCount |-> !streaming); // R2

  AST_FLUSH_ONLY_STREAMING: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flush |-> streaming); // R4

  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAITINIT && !xferDone) |=> (state == ST_WAITINIT)); // R9

  AST_STOP_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAITIDLE && !xferDone) |=> (state == ST_WAITIDLE)); // R9

endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int         COUNT_W   = 32,
  parameter int         CTL_W     = 3,
  parameter int         EN_BIT    = 0,
  parameter logic [7:0] COUNT_TOP = 8'h80
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         strobe,
  output logic               streaming,
  output logic               loadCount,
  output logic [COUNT_W-1:0] xferCount,
  output logic               clearBytes,
  output logic               initTrig,
  output logic               contTrig,
  output logic [CTL_W-1:0]   srcCtlN,
  output logic               streamIndN,
  output logic               flushPulse,
  output logic               skipPulse,
  output logic               cmdAck
);

  localparam int LOW_W = COUNT_W - 8;
  localparam logic [COUNT_W-1:0] LOAD_VAL = {COUNT_TOP, {LOW_W{1'b0}}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      streaming  <= 1'b0;
      streamIndN <= 1'b1;
      xferCount  <= '0;
    end else begin
      if (strobe.setFlag)      streaming <= 1'b1;
      else if (strobe.clrFlag) streaming <= 1'b0;
      if (strobe.indLow)       streamIndN <= 1'b0;
      else if (strobe.indHigh) streamIndN <= 1'b1;
      if (strobe.loadCount)    xferCount <= LOAD_VAL;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadCount  <= 1'b0;
      clearBytes <= 1'b0;
      initTrig   <= 1'b0;
      contTrig   <= 1'b0;
      flushPulse <= 1'b0;
      skipPulse  <= 1'b0;
      cmdAck     <= 1'b0;
    end else begin
      loadCount  <= strobe.loadCount;
      clearBytes <= strobe.clearBytes;
      initTrig   <= strobe.initTrig;
      contTrig   <= strobe.contTrig;
      flushPulse <= strobe.flush;
      skipPulse  <= strobe.skip;
      cmdAck     <= strobe.ack;
    end
  end

  for (genvar i = 0; i < CTL_W; i++) begin : gCtl
    if (i == EN_BIT) begin : gEn
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                srcCtlN[i] <= 1'b1;
        else if (strobe.enLow)                    srcCtlN[i] <= 1'b0;
        else if (strobe.enHigh || strobe.ctlAllHigh) srcCtlN[i] <= 1'b1;
      end
    end else begin : gAux
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                  srcCtlN[i] <= 1'b1;
        else if (strobe.ctlAllHigh) srcCtlN[i] <= 1'b1;
      end
    end
  end

  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    cmdAck |=> !cmdAck); // R7

  AST_INIT_ENABLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    initTrig |-> !srcCtlN[EN_BIT]); // R3

  AST_CONT_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    contTrig |-> (srcCtlN[EN_BIT] && !streamIndN)); // R3

  AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    skipPulse |-> (&srcCtlN && streamIndN)); // R4

  AST_FLUSH_IND_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    flushPulse |-> streamIndN); // R4

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    loadCount |-> (xferCount == LOAD_VAL)); // R2

endmodule

// File: rtl/stream_arm_sequencer.sv
module stream_arm_sequencer
  import seq_pkg::*;
#(
  parameter int         CMD_W     = 16,
  parameter int         COUNT_W   = 32,
  parameter int         CTL_W     = 3,
  parameter int         EN_BIT    = 0,
  parameter logic [7:0] COUNT_TOP = 8'h80
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdValid,
  input  logic [CMD_W-1:0]   cmdValue,
  input  logic               srcActive,
  input  logic               xferDone,
  output logic               loadCount,
  output logic [COUNT_W-1:0] xferCount,
  output logic               clearBytes,
  output logic               initTrig,
  output logic               contTrig,
  output logic [CTL_W-1:0]   srcCtlN,
  output logic               streamIndN,
  output logic               flushPulse,
  output logic               skipPulse,
  output logic               cmdAck
);

  seqStrobe_t strobe;
  logic       streaming;

  seq_ctrl #(.CMD_W(CMD_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .cmdValue  (cmdValue),
    .srcActive (srcActive),
    .xferDone  (xferDone),
    .streaming (streaming),
    .strobe    (strobe)
  );

  seq_datapath #(
    .COUNT_W   (COUNT_W),
    .CTL_W     (CTL_W),
    .EN_BIT    (EN_BIT),
    .COUNT_TOP (COUNT_TOP)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .streaming  (streaming),
    .loadCount  (loadCount),
    .xferCount  (xferCount),
    .clearBytes (clearBytes),
    .initTrig   (initTrig),
    .contTrig   (contTrig),
    .srcCtlN    (srcCtlN),
    .streamIndN (streamIndN),
    .flushPulse (flushPulse),
    .skipPulse  (skipPulse),
    .cmdAck     (cmdAck)
  );

endmodule

// File: tb/sim_stream_arm_sequencer.sv
`timescale 1ns/1ps
module sim_stream_arm_sequencer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [15:0] cmdValue = '0;
  logic        srcActive = 1'b1;
  logic        xferDone = 1'b1;
  logic        loadCount, clearBytes, initTrig, contTrig;
  logic [31:0] xferCount;
  logic [2:0]  srcCtlN;
  logic        streamIndN, flushPulse, skipPulse, cmdAck;

  always #2 clk = ~clk;

  stream_arm_sequencer u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdValue(cmdValue),
    .srcActive(srcActive), .xferDone(xferDone), .loadCount(loadCount),
    .xferCount(xferCount), .clearBytes(clearBytes), .initTrig(initTrig),
    .contTrig(contTrig), .srcCtlN(srcCtlN), .streamIndN(streamIndN),
    .flushPulse(flushPulse), .skipPulse(skipPulse), .cmdAck(cmdAck)
  );

  int nChk = 0, nFail = 0;
  int cyc = 0;
  int nLoad, nClr, nInit, nCont, nFlush, nSkip, nAck, nEnLow;
  int tLoad, tClr, tInit, tCont, tFlush, tSkip, tAck;
  logic [31:0] capCount;
  logic        indAtFlush, enAtInit, enAtCont, indAtCont;
  logic [2:0]  ctlAtSkip;
  int doneDelay = 0, doneCnt = 0;
  bit expStream = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearMon();
    nLoad = 0; nClr = 0; nInit = 0; nCont = 0; nFlush = 0; nSkip = 0; nAck = 0; nEnLow = 0;
    tLoad = 0; tClr = 0; tInit = 0; tCont = 0; tFlush = 0; tSkip = 0; tAck = 0;
  endtask

  // monitor and transfer-engine model, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (loadCount)  begin nLoad++; tLoad = cyc; capCount = xferCount; end
      if (clearBytes) begin nClr++; tClr = cyc; end
      if (initTrig)   begin nInit++; tInit = cyc; enAtInit = srcCtlN[0]; end
      if (contTrig)   begin nCont++; tCont = cyc; enAtCont = srcCtlN[0]; indAtCont = streamIndN; end
      if (flushPulse) begin nFlush++; tFlush = cyc; indAtFlush = streamIndN; end
      if (skipPulse)  begin nSkip++; tSkip = cyc; ctlAtSkip = srcCtlN; end
      if (cmdAck)     begin nAck++; tAck = cyc; end
      if (!srcCtlN[0]) nEnLow++;
      if ((initTrig || flushPulse) && doneDelay > 0) begin
        xferDone = 1'b0;
        doneCnt  = doneDelay;
      end else if (doneCnt > 0) begin
        doneCnt--;
        if (doneCnt == 0) xferDone = 1'b1;
      end
    end
  end

  task automatic strobeCmd(input logic [15:0] v, input bit act);
    @(negedge clk);
    cmdValue  = v;
    srcActive = act;
    cmdValid  = 1'b1;
    @(negedge clk);
    cmdValid  = 1'b0;
  endtask

  task automatic waitAcks(input int n);
    for (int k = 0; k < 80 && nAck < n; k++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic runCmd(input logic [15:0] v, input bit act, input int d);
    bit wantStart, doStart, doStop;
    logic [2:0] ctlBefore;
    logic indBefore;
    doneDelay = d;
    ctlBefore = srcCtlN;
    indBefore = streamIndN;
    clearMon();
    wantStart = act && (v != 0);
    doStart = wantStart && !expStream;
    doStop  = !wantStart && expStream;
    strobeCmd(v, act);
    waitAcks(1);
    chk(nAck == 1, "R7 one ack per command", nAck, 1);
    if (doStart) begin
      chk(nLoad == 1 && nClr == 1 && tClr == tLoad, "R2 load and clear together", nLoad, 1);
      chk(capCount == 32'h8000_0000, "R2 transfer count", capCount, 32'h8000_0000);
      chk(nInit == 1 && tInit == tLoad + 1 && !enAtInit, "R3 initial trigger with enable low", tInit - tLoad, 1);
      chk(tCont == tInit + 2 + d, "R9 init wait length", tCont - tInit, 2 + d);
      chk(nEnLow == 2 + d, "R3 enable low span", nEnLow, 2 + d);
      chk(enAtCont && !indAtCont, "R3 release with indicator low", {enAtCont, indAtCont}, 2'b10);
      chk(tAck == tCont + 1, "R7 ack after start", tAck - tCont, 1);
      chk(nFlush == 0 && nSkip == 0, "R2 no stop pulses in start", nFlush + nSkip, 0);
      expStream = 1;
    end else if (doStop) begin
      chk(nFlush == 1 && indAtFlush, act ? "R4 flush with indicator high" : "R5 inactive source stops",
          indAtFlush, 1);
      chk(nSkip == 1 && tSkip == tFlush + 2 + d, "R9 stop wait length", tSkip - tFlush, 2 + d);
      chk(ctlAtSkip == 3'b111, "R4 controls high at skip", ctlAtSkip, 3'b111);
      chk(tAck == tSkip + 1, "R7 ack after stop", tAck - tSkip, 1);
      chk(nLoad == 0 && nInit == 0 && nCont == 0, "R4 no start pulses in stop", nLoad + nInit + nCont, 0);
      expStream = 0;
    end else begin
      chk(nLoad + nClr + nInit + nCont + nFlush + nSkip == 0, "R6 redundant command is quiet",
          nLoad + nClr + nInit + nCont + nFlush + nSkip, 0);
      chk(srcCtlN == ctlBefore && streamIndN == indBefore, "R6 levels unchanged",
          {srcCtlN, streamIndN}, {ctlBefore, indBefore});
    end
    chk(streamIndN == !expStream, "R3 R4 indicator level", streamIndN, !expStream);
    chk(srcCtlN == 3'b111, "R1 R4 controls idle high", srcCtlN, 3'b111);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog R7 actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    logic [15:0] vals [4];
    vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'h8000; vals[3] = 16'hFFFF;
    clearMon();
    repeat (3) @(negedge clk);
    chk(srcCtlN == 3'b111 && streamIndN == 1'b1, "R1 reset levels", {srcCtlN, streamIndN}, 4'hF);
    chk({loadCount, clearBytes, initTrig, contTrig, flushPulse, skipPulse, cmdAck} == 0,
        "R1 no pulses in reset", {loadCount, initTrig, cmdAck}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(nAck == 0 && srcCtlN == 3'b111 && streamIndN, "R1 idle after reset", nAck, 0);

    for (int d = 0; d < 4; d++)
      for (int a = 0; a < 2; a++)
        for (int vi = 0; vi < 4; vi++)
          for (int pre = 0; pre < 2; pre++) begin
            runCmd(pre ? 16'h0001 : 16'h0000, 1'b1, 0);
            runCmd(vals[vi], a[0], d);
          end

    // R8: two commands land while a start is parked waiting for done
    runCmd(16'h0000, 1'b1, 0);
    doneDelay = 6;
    clearMon();
    strobeCmd(16'h0001, 1'b1);
    repeat (2) @(negedge clk);
    strobeCmd(16'h0005, 1'b1);
    strobeCmd(16'h0000, 1'b1);
    chk(nAck == 0, "R8 held command waits", nAck, 0);
    waitAcks(2);
    chk(nAck == 2, "R8 two acks for held pair", nAck, 2);
    chk(nLoad == 1 && nFlush == 1 && nSkip == 1, "R8 last held command served", nFlush, 1);
    chk(tFlush > tCont + 1, "R8 held served after first ack", tFlush - tCont, 2);
    chk(streamIndN == 1'b1, "R8 ends stopped", streamIndN, 1);
    expStream = 0;

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule